// File: doc/BRIEF.md
# Multi-Region Image Histogram Engine

This block builds intensity histograms from a raw pixel stream for up to four rectangular windows at once. Each pixel comes with a colour-phase tag. It is multiplied by the white-balance gain chosen by that tag, clipped to the largest pixel code, and shifted right to form a bin index. Every active window that contains the pixel's coordinates then increments its own counter for that bin. All windows share one counter memory. Asking for more windows leaves fewer bins for each window, and the bin count is capped to fit.

Software turns on collection with an enable input. A frame-start pulse opens a collection period and a frame-end pulse closes it. A busy output shows that a frame is being gathered or that a pixel is still on its way into memory. Results are read through a pointer port: a load sets the start word, and every read strobe returns the word at the pointer and steps the pointer by one. An optional clear mode zeroes each word as it is read, so one full pass both reads the memory and empties it.

Top module: `hist_engine`

## Requirements
- R1: A pixel counts in window r when h_start(r) <= x <= h_end(r) and v_start(r) <= y <= v_end(r), with inclusive bounds. Window r's bounds sit in bits [12r+11:12r] of each bound port. Overlapping windows each count the pixel. A window whose start is greater than its end matches nothing.
- R2: `cfg_regions_m1` holds the window count minus one (0 to 3). Windows with an index above it are never counted.
- R3: `cfg_bins_sel` values 0, 1, 2 and 3 select 32, 64, 128 and 256 bins. The bin index is the clipped gained value shifted right by 10 - log2(bins).
- R4: The bin count in use is the smaller of the selected count and the window cap. The cap is 256 for one window, 128 for two, and 64 for three or four windows. The shift follows the bin count in use.
- R5: The gained value is floor(pixel x gain / 32), clipped to 1023. The gain is unsigned with 3 integer and 5 fraction bits. In Bayer mode (`cfg_mode`=0), phase p uses gain p, taken from bits [8p+7:8p] of `cfg_gains`.
- R6: In three-channel mode (`cfg_mode`=1), phases 0 to 2 use gains 0 to 2, and phase 3 also uses gain 2. Gain 3 has no effect in this mode.
- R7: Counter words are laid out region-major. The word address is r x bins + bin index.
- R8: A counter at its maximum (2^CNT_W - 1) stays at that value and does not wrap.
- R9: `rd_addr_we` loads the pointer from `rd_addr`. Each `rd_strobe` places the word at the pointer, zero-extended to 32 bits, on `rd_data` after the next clock edge, and advances the pointer by one.
- R10: When `rd_clear` is high during a read strobe, the word that was read becomes zero. Without it, the word is kept.
- R11: With `cfg_enable` high, `frame_start` raises `busy` and opens collection, and `frame_end` closes it. `busy` falls once the last pixel has been written. Pixels that arrive outside a frame, or while the block is disabled, are not counted.
- R12: After reset, every counter is zero, `busy` is low, `rd_data` is zero and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Collection enable |
| cfg_bins_sel | input | 2 | Bin count select |
| cfg_regions_m1 | input | 2 | Active window count minus one |
| cfg_mode | input | 1 | 0 Bayer, 1 three-channel |
| cfg_gains | input | 32 | Four 8-bit gains, phase 0 in the low byte |
| cfg_h_start | input | 48 | Horizontal starts, 12 bits per window |
| cfg_h_end | input | 48 | Horizontal ends |
| cfg_v_start | input | 48 | Vertical starts |
| cfg_v_end | input | 48 | Vertical ends |
| frame_start | input | 1 | Frame start pulse |
| frame_end | input | 1 | Frame end pulse |
| pix_valid | input | 1 | Pixel qualifier |
| pix_value | input | 10 | Raw pixel value |
| pix_phase | input | 2 | Colour-phase tag |
| pix_x | input | 12 | Pixel column |
| pix_y | input | 12 | Pixel row |
| rd_addr_we | input | 1 | Load readout pointer |
| rd_addr | input | 8 | Pointer load value |
| rd_strobe | input | 1 | Read one word |
| rd_clear | input | 1 | Zero words as they are read |
| rd_data | output | 32 | Read word |
| busy | output | 1 | Frame or update in progress |

## Verification
Some properties are checked on every clock cycle: a staged bin index stays inside the bin count in use, windows above the active count never carry a hit, a saturated counter stays saturated, the pointer steps by one on each read, a clear-mode read leaves a zero behind, and busy rises after an enabled frame start. Other behaviour can only be shown by the bench's scenarios. These include the gain arithmetic and its clipping, the choice of gain by phase in each mode, the bin cap for each window count, the region-major addresses, the inclusive window edges, and the discarding of pixels outside a frame.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic {
    MODE_BAYER   = 1'b0,
    MODE_TRICHAN = 1'b1
  } color_mode_e;

  // smallest k with 2**k >= n, bounded loop
  function automatic int ceil_log2(input int n);
    int k;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if ((1 << i) < n) k = i + 1;
    end
    return k;
  endfunction

endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic frame_start,
  input  logic frame_end,
  input  logic pix_valid,
  input  logic stage_valid,
  output logic accept,
  output logic busy
);

  logic in_frame_q, in_frame_d;

  always_comb begin
    in_frame_d = in_frame_q;
    if (!enable)          in_frame_d = 1'b0;
    else if (frame_start) in_frame_d = 1'b1;
    else if (frame_end)   in_frame_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_frame_q <= 1'b0;
    else        in_frame_q <= in_frame_d;
  end

  assign accept = pix_valid && in_frame_q && enable;
  assign busy   = in_frame_q || stage_valid;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && frame_start) |=> busy); // R11

  AST_DISABLE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !accept); // R11

endmodule

// File: rtl/hist_region_match.sv
module hist_region_match #(
  parameter int NREG    = 4,
  parameter int COORD_W = 12,
  parameter int RSEL_W  = 2
) (
  input  logic [COORD_W-1:0]      x,
  input  logic [COORD_W-1:0]      y,
  input  logic [NREG*COORD_W-1:0] h_start,
  input  logic [NREG*COORD_W-1:0] h_end,
  input  logic [NREG*COORD_W-1:0] v_start,
  input  logic [NREG*COORD_W-1:0] v_end,
  input  logic [RSEL_W-1:0]       nreg_m1,
  output logic [NREG-1:0]         hit
);

  for (genvar r = 0; r < NREG; r++) begin : g_win
    logic [COORD_W-1:0] hs, he, vs, ve;
    logic               active, in_h, in_v;
    assign hs     = h_start[r*COORD_W +: COORD_W];
    assign he     = h_end  [r*COORD_W +: COORD_W];
    assign vs     = v_start[r*COORD_W +: COORD_W];
    assign ve     = v_end  [r*COORD_W +: COORD_W];
    assign active = (32'(nreg_m1) >= r);
    assign in_h   = (x >= hs) && (x <= he);
    assign in_v   = (y >= vs) && (y <= ve);
    assign hit[r] = active && in_h && in_v;
  end

endmodule

// File: rtl/hist_gain_bin.sv
module hist_gain_bin
  import hist_pkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int NPHASE    = 4,
  parameter int NREG      = 4,
  parameter int AW        = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic [PIX_W-1:0]         pix,
  input  logic [1:0]               phase,
  input  logic                     mode,
  input  logic [NPHASE*GAIN_W-1:0] gains,
  input  logic [3:0]               bin_log2,
  input  logic [NREG-1:0]          hit_in,
  output logic                     st_valid,
  output logic [AW-1:0]            st_bin,
  output logic [NREG-1:0]          st_hit
);

  localparam int              PROD_W  = PIX_W + GAIN_W;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  logic [1:0]        gsel;
  logic [GAIN_W-1:0] gain;
  logic [PROD_W-1:0] prod, scaled;
  logic [PIX_W-1:0]  clipped;
  logic [3:0]        shamt;
  logic [AW-1:0]     bin_new;

  always_comb begin
    gsel = phase;
    if (mode == MODE_TRICHAN && phase == 2'd3) gsel = 2'd2;
    gain    = gains[int'(gsel)*GAIN_W +: GAIN_W];
    prod    = PROD_W'(pix) * PROD_W'(gain);
    scaled  = prod >> GAIN_FRAC;
    clipped = (scaled > PROD_W'(PIX_MAX)) ? PIX_MAX : PIX_W'(scaled);
    shamt   = 4'(PIX_W) - bin_log2;
    bin_new = AW'(clipped >> shamt);
  end

  logic            valid_q, valid_d;
  logic [AW-1:0]   bin_q, bin_d;
  logic [NREG-1:0] hit_q, hit_d;

  always_comb begin
    valid_d = accept;
    bin_d   = bin_q;
    hit_d   = hit_q;
    if (accept) begin
      bin_d = bin_new;
      hit_d = hit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bin_q   <= '0;
      hit_q   <= '0;
    end else begin
      valid_q <= valid_d;
      bin_q   <= bin_d;
      hit_q   <= hit_d;
    end
  end

  assign st_valid = valid_q;
  assign st_bin   = bin_q;
  assign st_hit   = hit_q;

  AST_BIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (32'(st_bin) < (32'd1 << bin_log2))); // R3

endmodule

// File: rtl/hist_bin_mem.sv
module hist_bin_mem #(
  parameter int NREG  = 4,
  parameter int AW    = 8,
  parameter int CNT_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_bin,
  input  logic [NREG-1:0] st_hit,
  input  logic [3:0]      bin_log2,
  input  logic            rd_addr_we,
  input  logic [AW-1:0]   rd_addr,
  input  logic            rd_strobe,
  input  logic            rd_clear,
  output logic [31:0]     rd_data
);

  localparam int               DEPTH   = 1 << AW;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [DEPTH];
  logic [CNT_W-1:0] cnt_d [DEPTH];
  logic [AW-1:0]    upd_addr [NREG];
  logic [AW-1:0]    ptr_q, ptr_d;
  logic [31:0]      rd_data_q, rd_data_d;

  // region-major word address per window
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      upd_addr[r] = AW'(r << bin_log2) | st_bin;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    for (int r = 0; r < NREG; r++) begin
      if (st_valid && st_hit[r] && (cnt_q[upd_addr[r]] != CNT_MAX)) begin
        cnt_d[upd_addr[r]] = cnt_q[upd_addr[r]] + 1'b1;
      end
    end
    if (rd_strobe && rd_clear) cnt_d[ptr_q] = '0;
  end

  always_comb begin
    ptr_d     = ptr_q;
    rd_data_d = rd_data_q;
    if (rd_strobe) begin
      rd_data_d = 32'(cnt_q[ptr_q]);
      ptr_d     = ptr_q + 1'b1;
    end
    if (rd_addr_we) ptr_d = rd_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
      ptr_q     <= '0;
      rd_data_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= cnt_d[i];
      ptr_q     <= ptr_d;
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data = rd_data_q;

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !rd_addr_we) |=> (ptr_q == AW'($past(ptr_q) + 1'b1))); // R9

  AST_CLEAR_LEAVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_clear) |=> (cnt_q[$past(ptr_q)] == '0)); // R10

  for (genvar r = 0; r < NREG; r++) begin : g_sat_chk
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_hit[r] && (cnt_q[upd_addr[r]] == CNT_MAX) && !(rd_strobe && rd_clear))
      |=> (cnt_q[$past(upd_addr[r])] == CNT_MAX)); // R8
  end

endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int PIX_W        = 10,
  parameter int GAIN_W       = 8,
  parameter int GAIN_FRAC    = 5,
  parameter int NREG         = 4,
  parameter int COORD_W      = 12,
  parameter int CNT_W        = 20,
  parameter int MIN_BIN_LOG2 = 5,
  parameter int MAX_BIN_LOG2 = 8,
  parameter int NPHASE       = 4,
  localparam int RSEL_W      = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW          = MAX_BIN_LOG2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_enable,
  input  logic [1:0]                cfg_bins_sel,
  input  logic [RSEL_W-1:0]         cfg_regions_m1,
  input  logic                      cfg_mode,
  input  logic [NPHASE*GAIN_W-1:0]  cfg_gains,
  input  logic [NREG*COORD_W-1:0]   cfg_h_start,
  input  logic [NREG*COORD_W-1:0]   cfg_h_end,
  input  logic [NREG*COORD_W-1:0]   cfg_v_start,
  input  logic [NREG*COORD_W-1:0]   cfg_v_end,
  input  logic                      frame_start,
  input  logic                      frame_end,
  input  logic                      pix_valid,
  input  logic [PIX_W-1:0]          pix_value,
  input  logic [1:0]                pix_phase,
  input  logic [COORD_W-1:0]        pix_x,
  input  logic [COORD_W-1:0]        pix_y,
  input  logic                      rd_addr_we,
  input  logic [AW-1:0]             rd_addr,
  input  logic                      rd_strobe,
  input  logic                      rd_clear,
  output logic [31:0]               rd_data,
  output logic                      busy
);

  // bin count in use: selection capped by window count (shared memory)
  logic [3:0] sel_log2, cap_log2, eff_log2;

  always_comb begin
    sel_log2 = 4'(MIN_BIN_LOG2) + 4'(cfg_bins_sel);
    cap_log2 = 4'(MAX_BIN_LOG2);
    for (int n = 2; n <= NREG; n++) begin
      if (int'(cfg_regions_m1) + 1 >= n) cap_log2 = 4'(MAX_BIN_LOG2 - ceil_log2(n));
    end
    eff_log2 = (sel_log2 < cap_log2) ? sel_log2 : cap_log2;
  end

  logic            accept;
  logic [NREG-1:0] hit;
  logic            st_valid;
  logic [AW-1:0]   st_bin;
  logic [NREG-1:0] st_hit;

  hist_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .pix_valid   (pix_valid),
    .stage_valid (st_valid),
    .accept      (accept),
    .busy        (busy)
  );

  hist_region_match #(
    .NREG    (NREG),
    .COORD_W (COORD_W),
    .RSEL_W  (RSEL_W)
  ) u_match (
    .x       (pix_x),
    .y       (pix_y),
    .h_start (cfg_h_start),
    .h_end   (cfg_h_end),
    .v_start (cfg_v_start),
    .v_end   (cfg_v_end),
    .nreg_m1 (cfg_regions_m1),
    .hit     (hit)
  );

  hist_gain_bin #(
    .PIX_W     (PIX_W),
    .GAIN_W    (GAIN_W),
    .GAIN_FRAC (GAIN_FRAC),
    .NPHASE    (NPHASE),
    .NREG      (NREG),
    .AW        (AW)
  ) u_gain (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .pix      (pix_value),
    .phase    (pix_phase),
    .mode     (cfg_mode),
    .gains    (cfg_gains),
    .bin_log2 (eff_log2),
    .hit_in   (hit),
    .st_valid (st_valid),
    .st_bin   (st_bin),
    .st_hit   (st_hit)
  );

  hist_bin_mem #(
    .NREG  (NREG),
    .AW    (AW),
    .CNT_W (CNT_W)
  ) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_bin     (st_bin),
    .st_hit     (st_hit),
    .bin_log2   (eff_log2),
    .rd_addr_we (rd_addr_we),
    .rd_addr    (rd_addr),
    .rd_strobe  (rd_strobe),
    .rd_clear   (rd_clear),
    .rd_data    (rd_data)
  );

  AST_INACTIVE_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> ((32'(st_hit) >> (int'(cfg_regions_m1) + 1)) == 0)); // R2

  AST_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(cfg_enable)); // R11

  AST_BIN_FITS_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (32'(st_bin) < (32'd1 << (MAX_BIN_LOG2 - ceil_log2(int'(cfg_regions_m1) + 1))))); // R4

endmodule

// File: tb/hist_engine_bench.sv
module hist_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable;
  logic [1:0]  cfg_bins_sel;
  logic [1:0]  cfg_regions_m1;
  logic        cfg_mode;
  logic [31:0] cfg_gains;
  logic [47:0] cfg_h_start, cfg_h_end, cfg_v_start, cfg_v_end;
  logic        frame_start, frame_end, pix_valid;
  logic [9:0]  pix_value;
  logic [1:0]  pix_phase;
  logic [11:0] pix_x, pix_y;
  logic        rd_addr_we, rd_strobe, rd_clear;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data, rd_data_sat;
  logic        busy, busy_sat;

  int checks = 0;
  int errors = 0;

  logic [31:0] rbuf [DEPTH];
  logic [31:0] rbuf_sat [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  hist_engine u_hist_engine (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_bins_sel(cfg_bins_sel),
    .cfg_regions_m1(cfg_regions_m1), .cfg_mode(cfg_mode), .cfg_gains(cfg_gains),
    .cfg_h_start(cfg_h_start), .cfg_h_end(cfg_h_end), .cfg_v_start(cfg_v_start),
    .cfg_v_end(cfg_v_end), .frame_start(frame_start), .frame_end(frame_end),
    .pix_valid(pix_valid), .pix_value(pix_value), .pix_phase(pix_phase),
    .pix_x(pix_x), .pix_y(pix_y), .rd_addr_we(rd_addr_we), .rd_addr(rd_addr),
    .rd_strobe(rd_strobe), .rd_clear(rd_clear), .rd_data(rd_data), .busy(busy)
  );

  // narrow-counter copy for the saturation case
  hist_engine #(.CNT_W(3)) u_hist_engine_sat (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_bins_sel(cfg_bins_sel),
    .cfg_regions_m1(cfg_regions_m1), .cfg_mode(cfg_mode), .cfg_gains(cfg_gains),
    .cfg_h_start(cfg_h_start), .cfg_h_end(cfg_h_end), .cfg_v_start(cfg_v_start),
    .cfg_v_end(cfg_v_end), .frame_start(frame_start), .frame_end(frame_end),
    .pix_valid(pix_valid), .pix_value(pix_value), .pix_phase(pix_phase),
    .pix_x(pix_x), .pix_y(pix_y), .rd_addr_we(rd_addr_we), .rd_addr(rd_addr),
    .rd_strobe(rd_strobe), .rd_clear(rd_clear), .rd_data(rd_data_sat), .busy(busy_sat)
  );

  typedef struct packed {
    logic [1:0]  bsel;
    logic [1:0]  rsel;
    logic        mode;
    logic [9:0]  pix;
    logic [1:0]  ph;
    logic [11:0] x;
    logic [11:0] y;
    logic [7:0]  a1;
    logic [7:0]  a2;
    logic [1:0]  tot;
  } vec_t;

  // gains: p0=1.0 p1=2.0 p2=0.5 p3=255/32
  // windows: W0 x0-9 y0-9, W1 x5-14 y0-9, W2 x20-29 y20-29, W3 x30-39 y0-5
  // covers R1 (edges, overlap), R2 (inactive W3), R3, R4 (caps), R5, R6, R7
  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{2'd3, 2'd0, 1'b0, 10'd400,  2'd0, 12'd2,  12'd2,  8'd100, 8'd100, 2'd1},
    '{2'd3, 2'd1, 1'b0, 10'd400,  2'd1, 12'd7,  12'd3,  8'd100, 8'd228, 2'd2},
    '{2'd1, 2'd3, 1'b0, 10'd1000, 2'd3, 12'd32, 12'd2,  8'd255, 8'd255, 2'd1},
    '{2'd0, 2'd2, 1'b0, 10'd300,  2'd2, 12'd25, 12'd25, 8'd68,  8'd68,  2'd1},
    '{2'd0, 2'd2, 1'b0, 10'd300,  2'd0, 12'd32, 12'd2,  8'd105, 8'd105, 2'd0},
    '{2'd2, 2'd0, 1'b1, 10'd200,  2'd3, 12'd0,  12'd0,  8'd12,  8'd12,  2'd1},
    '{2'd2, 2'd0, 1'b0, 10'd200,  2'd3, 12'd0,  12'd0,  8'd127, 8'd127, 2'd1},
    '{2'd0, 2'd0, 1'b0, 10'd0,    2'd0, 12'd9,  12'd9,  8'd0,   8'd0,   2'd1},
    '{2'd0, 2'd0, 1'b0, 10'd0,    2'd0, 12'd10, 12'd9,  8'd0,   8'd0,   2'd0},
    '{2'd3, 2'd3, 1'b0, 10'd1023, 2'd0, 12'd6,  12'd1,  8'd63,  8'd127, 2'd2},
    '{2'd0, 2'd1, 1'b0, 10'd64,   2'd0, 12'd6,  12'd1,  8'd2,   8'd34,  2'd2},
    '{2'd3, 2'd0, 1'b0, 10'd511,  2'd1, 12'd3,  12'd3,  8'd255, 8'd255, 2'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic read_all(input logic clr);
    @(negedge clk);
    rd_addr_we = 1'b1; rd_addr = 8'd0; rd_clear = clr;
    @(negedge clk);
    rd_addr_we = 1'b0; rd_strobe = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      rbuf[i]     = rd_data;
      rbuf_sat[i] = rd_data_sat;
    end
    rd_strobe = 1'b0; rd_clear = 1'b0;
  endtask

  task automatic read_at(input logic [7:0] a, input logic clr,
                         output logic [31:0] v, output logic [31:0] vs);
    @(negedge clk);
    rd_addr_we = 1'b1; rd_addr = a; rd_clear = clr;
    @(negedge clk);
    rd_addr_we = 1'b0; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; rd_clear = 1'b0;
    v  = rd_data;
    vs = rd_data_sat;
  endtask

  task automatic run_frame(input logic [9:0] p, input logic [1:0] ph,
                           input logic [11:0] x, input logic [11:0] y, input int reps);
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    pix_value = p; pix_phase = ph; pix_x = x; pix_y = y; pix_valid = 1'b1;
    repeat (reps) @(negedge clk);
    pix_valid = 1'b0; frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int sum_buf();
    int s = 0;
    for (int i = 0; i < DEPTH; i++) s += int'(rbuf[i]);
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, vs;
    rst_n = 1'b0;
    cfg_enable = 1'b0; cfg_bins_sel = 2'd3; cfg_regions_m1 = 2'd0; cfg_mode = 1'b0;
    cfg_gains   = {8'd255, 8'd16, 8'd64, 8'd32};
    cfg_h_start = {12'd30, 12'd20, 12'd5, 12'd0};
    cfg_h_end   = {12'd39, 12'd29, 12'd14, 12'd9};
    cfg_v_start = {12'd0, 12'd20, 12'd0, 12'd0};
    cfg_v_end   = {12'd5, 12'd29, 12'd9, 12'd9};
    frame_start = 1'b0; frame_end = 1'b0; pix_valid = 1'b0;
    pix_value = '0; pix_phase = '0; pix_x = '0; pix_y = '0;
    rd_addr_we = 1'b0; rd_addr = '0; rd_strobe = 1'b0; rd_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    check("R12 busy after reset", 32'(busy), 32'd0);
    check("R12 rd_data after reset", rd_data, 32'd0);
    read_all(1'b0);
    check("R12 counters zero after reset", 32'(sum_buf()), 32'd0);

    // R11 disabled: frame and pixel ignored
    run_frame(10'd400, 2'd0, 12'd2, 12'd2, 1);
    check("R11 busy stays low when disabled", 32'(busy), 32'd0);
    read_all(1'b0);
    check("R11 no counts while disabled", 32'(sum_buf()), 32'd0);

    cfg_enable = 1'b1;
    // R11 pixel outside a frame ignored
    @(negedge clk); pix_value = 10'd400; pix_x = 12'd2; pix_y = 12'd2; pix_valid = 1'b1;
    @(negedge clk); pix_valid = 1'b0;
    repeat (2) @(negedge clk);
    read_all(1'b0);
    check("R11 no counts outside frame", 32'(sum_buf()), 32'd0);

    // R11 busy rises on start and falls after end
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    check("R11 busy high in frame", 32'(busy), 32'd1);
    frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 busy low after frame", 32'(busy), 32'd0);

    // vector table
    for (int k = 0; k < NVEC; k++) begin
      read_all(1'b1);
      cfg_bins_sel = VEC[k].bsel; cfg_regions_m1 = VEC[k].rsel; cfg_mode = VEC[k].mode;
      run_frame(VEC[k].pix, VEC[k].ph, VEC[k].x, VEC[k].y, 1);
      read_all(1'b0);
      check($sformatf("R7 vector %0d first word", k), rbuf[VEC[k].a1],
            (VEC[k].tot != 0) ? 32'd1 : 32'd0);
      if (VEC[k].tot == 2'd2)
        check($sformatf("R1 vector %0d overlap word", k), rbuf[VEC[k].a2], 32'd1);
      check($sformatf("R2 vector %0d total hits", k), 32'(sum_buf()), 32'(VEC[k].tot));
    end

    // R9 pointer load and auto-increment, R10 keep vs clear
    read_all(1'b1);
    cfg_bins_sel = 2'd3; cfg_regions_m1 = 2'd0; cfg_mode = 1'b0;
    run_frame(10'd400, 2'd0, 12'd2, 12'd2, 1);
    @(negedge clk); rd_addr_we = 1'b1; rd_addr = 8'd99;
    @(negedge clk); rd_addr_we = 1'b0; rd_strobe = 1'b1;
    @(negedge clk); check("R9 word at loaded pointer", rd_data, 32'd0);
    @(negedge clk); check("R9 next word after increment", rd_data, 32'd1);
    rd_strobe = 1'b0;
    read_at(8'd100, 1'b0, v, vs);
    check("R10 word kept without clear", v, 32'd1);
    read_at(8'd100, 1'b1, v, vs);
    check("R10 clear read returns value", v, 32'd1);
    read_at(8'd100, 1'b0, v, vs);
    check("R10 word zero after clear read", v, 32'd0);

    // R8 saturation on narrow copy, wide copy keeps counting
    read_all(1'b1);
    run_frame(10'd400, 2'd0, 12'd2, 12'd2, 10);
    read_at(8'd100, 1'b0, v, vs);
    check("R8 wide counter", v, 32'd10);
    check("R8 narrow counter saturates", vs, 32'd7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule